// File: doc/BRIEF.md
# Tree Pseudo-LRU Victim Selector

This block holds the replacement state of a four-way set-associative cache. Every set owns three bits that form a two-level binary tree over its ways. When the cache reports a hit or a fill, it gives a set number and a way number. The block then rewrites the bits on that way's path so that the tree steers away from the way just used. The result is a cheap approximation of least-recently-used order.

A separate query port names a set and returns, without a clock cycle of delay, the way that should be evicted. That way is found by walking the tree from its root. A per-way valid mask comes with the query. If any way in the set holds no line, the lowest-numbered empty way is chosen and the tree is ignored.

The state sits in flip-flops and the number of sets is a parameter. Tag compare, data storage and exact recency ordering belong to other blocks.

Top module: `plru_victim_sel`

## Requirements
- R1: After reset every bit of every set is 0, so a query on any set with all ways valid returns way 0.
- R2: After an access to way w of set s, a query on set s with all ways valid returns a way other than w, until set s is accessed again.
- R3: An access rewrites the tree bits of its set as follows. The top bit becomes 1 for an access to way 0 or 1, and 0 for way 2 or 3. The way-0/1 pair bit becomes 1 for way 0 and 0 for way 1. The way-2/3 pair bit becomes 1 for way 2 and 0 for way 3. A pair bit of 0 selects the lower way of the pair and 1 selects the upper way.
- R4: With all ways valid, the victim is found by reading the top bit first. A top bit of 0 picks the way-0/1 pair and uses that pair's bit. A top bit of 1 picks the way-2/3 pair and uses that pair's bit.
- R5: An access leaves unchanged the pair bit of the pair that does not contain the accessed way.
- R6: An access to one set changes no bit of any other set.
- R7: While acc_valid is 0, no set's bits change, whatever acc_set and acc_way hold.
- R8: When a query and an access target the same set in one cycle, vic_way reflects the bits as they stood before that access.
- R9: When vic_valid_mask (bit i = 1 means way i holds a line) is not all ones, vic_way is the lowest-numbered way whose mask bit is 0, regardless of the tree bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Hit or fill to record this cycle |
| acc_set | input | SET_W | Set of the recorded access |
| acc_way | input | 2 | Way of the recorded access |
| vic_set | input | SET_W | Set being asked for a victim |
| vic_valid_mask | input | 4 | Per-way line-present flags of the queried set |
| vic_way | output | 2 | Way to evict from the queried set |

## Verification
An access and a victim query can name the same set in the same cycle. The bench provokes this with directed cases, and also throughout a long pseudo-random sweep in which both ports are active on every cycle and often collide. In each such cycle the victim is sampled after the inputs settle and before the clock edge. It is compared with a model whose bits have not yet taken in that access. The next cycle then confirms that the update did land.

// File: rtl/plru_pkg.sv
package plru_pkg;
  localparam int WAYS = 4;

  typedef logic [1:0] way_t;
  // [0] top bit, [1] pair bit for ways 0/1, [2] pair bit for ways 2/3
  typedef logic [2:0] tree_t;

  function automatic way_t tree_walk(tree_t t);
    way_t w;
    if (t[0]) w = {1'b1, t[2]};
    else      w = {1'b0, t[1]};
    return w;
  endfunction

  function automatic tree_t tree_touch(tree_t t, way_t w);
    tree_t n;
    n    = t;
    n[0] = ~w[1];
    if (w[1]) n[2] = ~w[0];
    else      n[1] = ~w[0];
    return n;
  endfunction

  function automatic way_t first_empty(logic [WAYS-1:0] present);
    way_t w;
    w = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!present[i]) w = way_t'(i);
    end
    return w;
  endfunction
endpackage

// File: rtl/plru_tree_store.sv
module plru_tree_store
  import plru_pkg::*;
#(
  parameter int NUM_SETS = 64,
  parameter int SET_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  tree_t            wr_bits,
  input  logic [SET_W-1:0] acc_set,
  output tree_t            acc_bits,
  input  logic [SET_W-1:0] qry_set,
  output tree_t            qry_bits
);
  tree_t bits_q [NUM_SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) bits_q[s] <= '0;
    end else if (wr_en) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        if (wr_set == SET_W'(s)) bits_q[s] <= wr_bits;
      end
    end
  end

  assign acc_bits = bits_q[acc_set];
  assign qry_bits = bits_q[qry_set];

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_chk
    AST_SET_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_set == SET_W'(g)) |=> $stable(bits_q[g])); // R6
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(qry_bits) || $past(qry_set) != qry_set); // R7
endmodule

// File: rtl/plru_touch.sv
module plru_touch
  import plru_pkg::*;
(
  input  tree_t cur_bits,
  input  way_t  way,
  output tree_t nxt_bits
);
  assign nxt_bits = tree_touch(cur_bits, way);
endmodule

// File: rtl/plru_pick.sv
module plru_pick
  import plru_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  tree_t               bits,
  input  logic [WAYS-1:0]     present,
  output way_t                way
);
  logic all_full;
  way_t tree_way;
  way_t empty_way;

  assign all_full  = &present;
  assign tree_way  = tree_walk(bits);
  assign empty_way = first_empty(present);
  assign way       = all_full ? tree_way : empty_way;

  AST_EMPTY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !all_full |-> !present[way]
      && (way < 2'd1 || present[0])
      && (way < 2'd2 || present[1])
      && (way < 2'd3 || present[2])); // R9
endmodule

// File: rtl/plru_victim_sel.sv
module plru_victim_sel
  import plru_pkg::*;
#(
  parameter  int NUM_SETS = 64,
  localparam int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [SET_W-1:0] acc_set,
  input  logic [1:0]       acc_way,
  input  logic [SET_W-1:0] vic_set,
  input  logic [3:0]       vic_valid_mask,
  output logic [1:0]       vic_way
);
  tree_t acc_cur_bits;
  tree_t acc_nxt_bits;
  tree_t qry_bits;

  plru_tree_store #(.NUM_SETS(NUM_SETS), .SET_W(SET_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (acc_valid),
    .wr_set   (acc_set),
    .wr_bits  (acc_nxt_bits),
    .acc_set  (acc_set),
    .acc_bits (acc_cur_bits),
    .qry_set  (vic_set),
    .qry_bits (qry_bits)
  );

  plru_touch u_touch (
    .cur_bits (acc_cur_bits),
    .way      (acc_way),
    .nxt_bits (acc_nxt_bits)
  );

  plru_pick u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .bits    (qry_bits),
    .present (vic_valid_mask),
    .way     (vic_way)
  );

  AST_LOW_PAIR_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_way[1] |-> acc_nxt_bits[2] == acc_cur_bits[2]); // R5
  AST_HIGH_PAIR_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_way[1] |-> acc_nxt_bits[1] == acc_cur_bits[1]); // R5
  AST_NOT_JUST_USED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> vic_set != $past(acc_set) || vic_valid_mask != 4'hF
                  || vic_way != $past(acc_way)); // R2
endmodule

// File: tb/test_plru_victim_sel.sv
module test_plru_victim_sel;
  localparam int NS = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic [2:0] acc_set = '0;
  logic [1:0] acc_way = '0;
  logic [2:0] vic_set = '0;
  logic [3:0] vic_valid_mask = 4'hF;
  logic [1:0] vic_way;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [2:0] m [NS];

  always #4 clk = ~clk;

  plru_victim_sel #(.NUM_SETS(NS)) i_plru_victim_sel (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_way(acc_way), .vic_set(vic_set), .vic_valid_mask(vic_valid_mask),
    .vic_way(vic_way)
  );

  function automatic logic [1:0] exp_way(logic [2:0] t, logic [3:0] mask);
    if (mask != 4'hF) begin
      for (int i = 0; i < 4; i++) if (!mask[i]) return 2'(i);
    end
    case ({t[0], t[2], t[1]})
      3'b000, 3'b010: return 2'd0;
      3'b001, 3'b011: return 2'd1;
      3'b100, 3'b101: return 2'd2;
      default:        return 2'd3;
    endcase
  endfunction

  function automatic logic [2:0] exp_touch(logic [2:0] t, logic [1:0] w);
    logic [2:0] n = t;
    case (w)
      2'd0: begin n[0] = 1'b1; n[1] = 1'b1; end
      2'd1: begin n[0] = 1'b1; n[1] = 1'b0; end
      2'd2: begin n[0] = 1'b0; n[2] = 1'b1; end
      default: begin n[0] = 1'b0; n[2] = 1'b0; end
    endcase
    return n;
  endfunction

  task automatic check(string req, logic [1:0] got, logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: vic_way=%0d expected %0d", req, got, exp);
    end
  endtask

  // Called at a falling edge: drive, settle, check, take the rising edge.
  task automatic cyc(input logic av, input logic [2:0] as, input logic [1:0] aw,
                     input logic [2:0] qs, input logic [3:0] mk, input string req);
    acc_valid = av; acc_set = as; acc_way = aw;
    vic_set = qs; vic_valid_mask = mk;
    #1;
    check(req, vic_way, exp_way(m[qs], mk));
    @(posedge clk);
    if (av) m[as] = exp_touch(m[as], aw);
    @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_up();
  end

  initial begin
    for (int s = 0; s < NS; s++) m[s] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: every set reports way 0 after reset
    for (int s = 0; s < NS; s++) cyc(1'b0, 3'd0, 2'd0, 3'(s), 4'hF, "R1");

    // R3: one access to way 1 of a fresh set gives way 2 as victim
    cyc(1'b1, 3'd1, 2'd1, 3'd1, 4'hF, "R8");
    check("R3", vic_way, 2'd2);

    // R5: way 2 then way 0; the upper pair bit stays 1, so way 3
    cyc(1'b1, 3'd2, 2'd2, 3'd2, 4'hF, "R4");
    cyc(1'b1, 3'd2, 2'd0, 3'd2, 4'hF, "R8");
    check("R5", vic_way, 2'd3);

    // R2: each way in turn, then query the same set
    for (int w = 0; w < 4; w++) begin
      cyc(1'b1, 3'd3, 2'(w), 3'd0, 4'hF, "R6");
      vic_set = 3'd3; #1;
      checks++;
      if (vic_way === 2'(w)) begin
        fails++;
        $display("FAIL R2: vic_way=%0d expected not %0d", vic_way, w);
      end
      check("R4", vic_way, exp_way(m[3], 4'hF));
    end

    // R7: idle accesses with noisy set/way leave every set unchanged
    for (int i = 0; i < 8; i++) cyc(1'b0, 3'(i), 2'(i), 3'(i), 4'hF, "R7");

    // R8: same-set collision, checked before the edge, then after
    cyc(1'b1, 3'd4, 2'd0, 3'd4, 4'hF, "R8");
    cyc(1'b1, 3'd4, 2'd3, 3'd4, 4'hF, "R8");
    cyc(1'b0, 3'd4, 2'd0, 3'd4, 4'hF, "R8");

    // R9: every partly empty mask on several tree states
    for (int s = 1; s < 5; s++)
      for (int mk = 0; mk < 15; mk++) cyc(1'b0, 3'd0, 2'd0, 3'(s), 4'(mk), "R9");

    // R4/R6: long sweep with both ports busy and frequent collisions
    for (int i = 0; i < 2000; i++) begin
      automatic logic [2:0] as = 3'((i * 5 + i / 7) % NS);
      automatic logic [1:0] aw = 2'((i * 3 + i / 4) % 4);
      automatic logic [2:0] qs = 3'((i % 3 == 0) ? as : (i * 3 + 1) % NS);
      automatic logic [3:0] mk = (i % 11 == 0) ? 4'((i / 11) % 15) : 4'hF;
      cyc((i % 9) != 0, as, aw, qs, mk, "R4");
    end

    finish_up();
  end
endmodule